// File: doc/BRIEF.md
# Interrupt Controller Register Front End

This block is the byte-wide bus face of one 8-input programmable interrupt controller. A host talks to it through a small synchronous bus. The bus has a write strobe, a read strobe, a 2-bit address and 8-bit write and read data. Three addresses are live:

| Address | Port |
|---|---|
| 0 | command |
| 1 | data |
| 2 | trigger mode |

A command-port write is sorted by bit tests into one of three kinds: a start-of-initialization word, a read/poll/special-mask control word, or an end-of-interrupt / priority control word. The data port means different things depending on where the initialization sequence stands.

The block owns the mask register, the vector base, the trigger-mode byte and the mode flags. It forwards end-of-interrupt style commands as one-cycle strobes to a separate priority core. That core keeps the request and in-service registers and the pending-level result, and hands them back for reads.

A read returns its byte one cycle after the read strobe. Depending on the port and the armed state, that byte is a one-shot poll result, the in-service bits, the request bits, the mask, or the trigger-mode byte. All strobes to the core are registered and appear in the cycle after the write that caused them.

Top module: `pic_cmd_frontend`

## Requirements
- R1: A command write is classified by its bits. Bit 4 set makes it an init-start word. Bit 4 clear with bit 3 set makes it a read-control word. Any other command write is a priority-control word: it raises `ocw2_stb_o` for exactly one cycle (the cycle after the write), with `ocw2_op_o` = bits 7:5 and `ocw2_lvl_o` = bits 2:0.
- R2: An init-start word does all of the following:
  - raises `init_stb_o` for one cycle;
  - clears the mask, the special-mask flag and the read-select flag;
  - makes the next data write the vector-base word;
  - if its bit 0 is clear, also clears the nested and auto-EOI flags (bit 0 set means a fourth word will follow).
- R3: The vector-base data write stores bits 7:3 on `vec_base_o`; the low three bits are ignored.
- R4: The data write after the vector base is discarded: mask and vector base are unchanged. The sequence then expects the mode word if one was requested, and otherwise returns to idle.
- R5: The mode word sets the nested flag from bit 4 and the auto-EOI flag from bit 1, then returns to idle.
- R6: A data write while idle, or while uninitialized after reset, loads the mask. A data-port read with no poll armed returns the mask.
- R7: In a read-control word, bit 1 set lets bit 0 choose what a command-port read returns: 1 selects the core in-service bits, 0 the core request bits. With bit 1 clear, the choice is unchanged.
- R8: In a read-control word, bit 6 set loads the special-mask flag from bit 5. With bit 6 clear, the flag is unchanged.
- R9: A read-control word with bit 2 set arms a one-shot poll. The next read of the command or data port returns the poll byte and raises `poll_ack_o` for one cycle. The poll byte is 8'h80 plus the pending level when the core reports a pending request, and 8'h07 otherwise. The read after it is a normal read.
- R10: Address 2 holds the trigger-mode byte: a write loads it, a read returns it, and `trig_mode_o` shows it.
- R11: Writes to address 3 change nothing, and reads from address 3 return zero. `bus_rdata` is zero in every cycle that does not follow a read strobe.
- R12: A priority-control word with bits 7:5 = 3'b100 sets the rotate-on-auto-EOI flag, and one with 3'b000 clears it. Other operation codes leave the flag unchanged.
- R13: After synchronous reset, all outputs are zero and the block is uninitialized.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| bus_wr | input | 1 | write strobe |
| bus_rd | input | 1 | read strobe |
| bus_addr | input | 2 | port address |
| bus_wdata | input | 8 | write data |
| bus_rdata | output | 8 | read data, valid the cycle after `bus_rd` |
| core_irr | input | 8 | request bits from the priority core |
| core_isr | input | 8 | in-service bits from the priority core |
| core_pend | input | 1 | core has a pending request |
| core_pend_lvl | input | 3 | level of the pending request |
| mask_o | output | 8 | interrupt mask |
| vec_base_o | output | 5 | vector base bits 7:3 |
| trig_mode_o | output | 8 | trigger-mode byte (1 = level) |
| nested_o | output | 1 | special fully nested mode |
| auto_eoi_o | output | 1 | automatic end of interrupt |
| rot_aeoi_o | output | 1 | rotate on automatic end of interrupt |
| spec_mask_o | output | 1 | special mask mode |
| init_stb_o | output | 1 | one-cycle init-start strobe to the core |
| ocw2_stb_o | output | 1 | one-cycle priority-command strobe |
| ocw2_op_o | output | 3 | priority-command operation code |
| ocw2_lvl_o | output | 3 | priority-command level |
| poll_ack_o | output | 1 | one-cycle strobe when a poll read completes |

## Verification
Every one of the 256 command bytes is written in turn, and each is followed by a command-port read. This catches a decoder that tests bit 3 before bit 4: it would misfile init words as read-control words, and the strobes or the read-select model would diverge. A poll that is not cleared by its own read would return a poll byte on the following read instead of the register.

Initialization runs with and without the fourth word. A design that skips the discard of word 3 would load that word into the mask. A design that ignores the fourth-word flag would treat the mask write after word 3 as a mode word. Writes to the unused address and idle cycles are checked to leave the read data at zero.

// File: rtl/pic_fe_pkg.sv
package pic_fe_pkg;

    localparam int BYTE_W = 8;
    localparam int LVL_W  = 3;
    localparam int BASE_W = BYTE_W - LVL_W;

    typedef enum logic [2:0] {
        INIT_NONE,
        INIT_IDLE,
        INIT_W2,
        INIT_W3,
        INIT_W4
    } init_st_e;

    typedef enum logic [1:0] {
        CMD_ICW1,
        CMD_OCW3,
        CMD_OCW2
    } cmd_kind_e;

    typedef struct packed {
        logic nested;
        logic auto_eoi;
    } mode_bits_t;

    localparam logic [2:0] OP_ROT_AEOI_SET = 3'b100;
    localparam logic [2:0] OP_ROT_AEOI_CLR = 3'b000;
    localparam logic [BYTE_W-1:0] POLL_NONE = 8'h07;

    function automatic cmd_kind_e classify(input logic [BYTE_W-1:0] b);
        if (b[4])      return CMD_ICW1;
        else if (b[3]) return CMD_OCW3;
        else           return CMD_OCW2;
    endfunction

    function automatic logic [BYTE_W-1:0] poll_byte(input logic pend,
                                                   input logic [LVL_W-1:0] lvl);
        if (pend) return {1'b1, {(BYTE_W-LVL_W-1){1'b0}}, lvl};
        else      return POLL_NONE;
    endfunction

endpackage

// File: rtl/pic_cmd_decode.sv
module pic_cmd_decode
    import pic_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_wr,
    input  logic [BYTE_W-1:0] wbyte,
    output logic              icw1_hit,
    output logic              poll_set,
    output logic              init_stb,
    output logic              ocw2_stb,
    output logic [2:0]        ocw2_op,
    output logic [LVL_W-1:0]  ocw2_lvl,
    output logic              rot_aeoi,
    output logic              spec_mask,
    output logic              read_isr
);

    cmd_kind_e kind;
    logic      ocw3_hit;
    logic      ocw2_hit;

    always_comb begin
        kind     = classify(wbyte);
        icw1_hit = cmd_wr && (kind == CMD_ICW1);
        ocw3_hit = cmd_wr && (kind == CMD_OCW3);
        ocw2_hit = cmd_wr && (kind == CMD_OCW2);
        poll_set = ocw3_hit && wbyte[2];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            init_stb  <= 1'b0;
            ocw2_stb  <= 1'b0;
            ocw2_op   <= '0;
            ocw2_lvl  <= '0;
            rot_aeoi  <= 1'b0;
            spec_mask <= 1'b0;
            read_isr  <= 1'b0;
        end else begin
            init_stb <= icw1_hit;
            ocw2_stb <= ocw2_hit;
            if (icw1_hit) begin
                spec_mask <= 1'b0;
                read_isr  <= 1'b0;
            end
            if (ocw3_hit) begin
                if (wbyte[1]) read_isr  <= wbyte[0];
                if (wbyte[6]) spec_mask <= wbyte[5];
            end
            if (ocw2_hit) begin
                ocw2_op  <= wbyte[7:5];
                ocw2_lvl <= wbyte[LVL_W-1:0];
                if (wbyte[7:5] == OP_ROT_AEOI_SET) rot_aeoi <= 1'b1;
                if (wbyte[7:5] == OP_ROT_AEOI_CLR) rot_aeoi <= 1'b0;
            end
        end
    end

    assert_strobe_fields_R1: assert property (@(posedge clk) disable iff (rst)
        ocw2_stb |-> (ocw2_op == $past(wbyte[7:5]) && ocw2_lvl == $past(wbyte[2:0])));

    assert_one_kind_R1: assert property (@(posedge clk) disable iff (rst)
        $onehot0({init_stb, ocw2_stb}));

    assert_init_clears_flags_R2: assert property (@(posedge clk) disable iff (rst)
        init_stb |-> (!spec_mask && !read_isr));

    assert_rot_kept_R12: assert property (@(posedge clk) disable iff (rst)
        (ocw2_stb && ocw2_op != OP_ROT_AEOI_SET && ocw2_op != OP_ROT_AEOI_CLR)
        |-> $stable(rot_aeoi));

endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
    import pic_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              icw1_hit,
    input  logic              data_wr,
    input  logic [BYTE_W-1:0] wbyte,
    output init_st_e          state,
    output logic [BYTE_W-1:0] imr,
    output logic [BASE_W-1:0] vec_base,
    output mode_bits_t        modes
);

    logic need_w4;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= INIT_NONE;
            imr      <= '0;
            vec_base <= '0;
            modes    <= '0;
            need_w4  <= 1'b0;
        end else if (icw1_hit) begin
            need_w4 <= wbyte[0];
            state   <= INIT_W2;
            imr     <= '0;
            if (!wbyte[0]) modes <= '0;
        end else if (data_wr) begin
            case (state)
                INIT_NONE, INIT_IDLE: imr <= wbyte;
                INIT_W2: begin
                    vec_base <= wbyte[BYTE_W-1:LVL_W];
                    state    <= INIT_W3;
                end
                INIT_W3: state <= need_w4 ? INIT_W4 : INIT_IDLE;
                INIT_W4: begin
                    modes.nested   <= wbyte[4];
                    modes.auto_eoi <= wbyte[1];
                    state          <= INIT_IDLE;
                end
                default: state <= INIT_IDLE;
            endcase
        end
    end

    assert_icw1_entry_R2: assert property (@(posedge clk) disable iff (rst)
        icw1_hit |=> (state == INIT_W2 && imr == '0));

    assert_base_store_R3: assert property (@(posedge clk) disable iff (rst)
        (data_wr && !icw1_hit && state == INIT_W2)
        |=> (vec_base == $past(wbyte[7:3]) && state == INIT_W3));

    assert_word3_discard_R4: assert property (@(posedge clk) disable iff (rst)
        (data_wr && !icw1_hit && state == INIT_W3)
        |=> ((state == INIT_W4 || state == INIT_IDLE) && $stable(imr) && $stable(vec_base)));

    assert_mode_word_R5: assert property (@(posedge clk) disable iff (rst)
        (data_wr && !icw1_hit && state == INIT_W4)
        |=> (state == INIT_IDLE && modes.nested == $past(wbyte[4])
             && modes.auto_eoi == $past(wbyte[1])));

    assert_mask_load_R6: assert property (@(posedge clk) disable iff (rst)
        (data_wr && !icw1_hit && (state == INIT_IDLE || state == INIT_NONE))
        |=> imr == $past(wbyte));

endmodule

// File: rtl/pic_read_port.sv
module pic_read_port
    import pic_fe_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              poll_set,
    input  logic              rd_cmd,
    input  logic              rd_dat,
    input  logic              rd_trig,
    input  logic              read_isr,
    input  logic [BYTE_W-1:0] irr,
    input  logic [BYTE_W-1:0] isr,
    input  logic [BYTE_W-1:0] imr,
    input  logic [BYTE_W-1:0] trig,
    input  logic              pend,
    input  logic [LVL_W-1:0]  pend_lvl,
    output logic [BYTE_W-1:0] rdata,
    output logic              poll_ack
);

    logic poll_armed;
    logic poll_read;

    assign poll_read = poll_armed && (rd_cmd || rd_dat);

    always_ff @(posedge clk) begin
        if (rst) begin
            poll_armed <= 1'b0;
            poll_ack   <= 1'b0;
            rdata      <= '0;
        end else begin
            poll_ack <= poll_read;
            rdata    <= '0;
            if (poll_read) begin
                rdata      <= poll_byte(pend, pend_lvl);
                poll_armed <= 1'b0;
            end else if (rd_cmd) begin
                rdata <= read_isr ? isr : irr;
            end else if (rd_dat) begin
                rdata <= imr;
            end else if (rd_trig) begin
                rdata <= trig;
            end
            if (poll_set) poll_armed <= 1'b1;
        end
    end

    assert_quiet_bus_R11: assert property (@(posedge clk) disable iff (rst)
        !(rd_cmd || rd_dat || rd_trig) |=> rdata == '0);

    assert_poll_value_R9: assert property (@(posedge clk) disable iff (rst)
        poll_ack |-> rdata == poll_byte($past(pend), $past(pend_lvl)));

    assert_poll_oneshot_R9: assert property (@(posedge clk) disable iff (rst)
        (poll_ack && !$past(poll_set)) |-> !poll_armed);

endmodule

// File: rtl/pic_cmd_frontend.sv
module pic_cmd_frontend
    import pic_fe_pkg::*;
#(
    parameter logic [1:0] ADDR_CMD  = 2'd0,
    parameter logic [1:0] ADDR_DATA = 2'd1,
    parameter logic [1:0] ADDR_TRIG = 2'd2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [1:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata,
    input  logic [7:0]  core_irr,
    input  logic [7:0]  core_isr,
    input  logic        core_pend,
    input  logic [2:0]  core_pend_lvl,
    output logic [7:0]  mask_o,
    output logic [4:0]  vec_base_o,
    output logic [7:0]  trig_mode_o,
    output logic        nested_o,
    output logic        auto_eoi_o,
    output logic        rot_aeoi_o,
    output logic        spec_mask_o,
    output logic        init_stb_o,
    output logic        ocw2_stb_o,
    output logic [2:0]  ocw2_op_o,
    output logic [2:0]  ocw2_lvl_o,
    output logic        poll_ack_o
);

    logic       wr_cmd, wr_dat, wr_trig;
    logic       rd_cmd, rd_dat, rd_trig;
    logic       icw1_hit, poll_set, read_isr;
    init_st_e   init_state;
    mode_bits_t modes;
    logic [7:0] trig_q;

    always_comb begin
        wr_cmd  = bus_wr && (bus_addr == ADDR_CMD);
        wr_dat  = bus_wr && (bus_addr == ADDR_DATA);
        wr_trig = bus_wr && (bus_addr == ADDR_TRIG);
        rd_cmd  = bus_rd && (bus_addr == ADDR_CMD);
        rd_dat  = bus_rd && (bus_addr == ADDR_DATA);
        rd_trig = bus_rd && (bus_addr == ADDR_TRIG);
    end

    always_ff @(posedge clk) begin
        if (rst)          trig_q <= '0;
        else if (wr_trig) trig_q <= bus_wdata;
    end

    pic_cmd_decode u_dec (
        .clk       (clk),
        .rst       (rst),
        .cmd_wr    (wr_cmd),
        .wbyte     (bus_wdata),
        .icw1_hit  (icw1_hit),
        .poll_set  (poll_set),
        .init_stb  (init_stb_o),
        .ocw2_stb  (ocw2_stb_o),
        .ocw2_op   (ocw2_op_o),
        .ocw2_lvl  (ocw2_lvl_o),
        .rot_aeoi  (rot_aeoi_o),
        .spec_mask (spec_mask_o),
        .read_isr  (read_isr)
    );

    pic_init_seq u_init (
        .clk      (clk),
        .rst      (rst),
        .icw1_hit (icw1_hit),
        .data_wr  (wr_dat),
        .wbyte    (bus_wdata),
        .state    (init_state),
        .imr      (mask_o),
        .vec_base (vec_base_o),
        .modes    (modes)
    );

    pic_read_port u_rd (
        .clk      (clk),
        .rst      (rst),
        .poll_set (poll_set),
        .rd_cmd   (rd_cmd),
        .rd_dat   (rd_dat),
        .rd_trig  (rd_trig),
        .read_isr (read_isr),
        .irr      (core_irr),
        .isr      (core_isr),
        .imr      (mask_o),
        .trig     (trig_q),
        .pend     (core_pend),
        .pend_lvl (core_pend_lvl),
        .rdata    (bus_rdata),
        .poll_ack (poll_ack_o)
    );

    assign trig_mode_o = trig_q;
    assign nested_o    = modes.nested;
    assign auto_eoi_o  = modes.auto_eoi;

    assert_trig_load_R10: assert property (@(posedge clk) disable iff (rst)
        wr_trig |=> trig_mode_o == $past(bus_wdata));

    assert_unused_addr_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 2'd3) |=> ($stable(trig_mode_o) && $stable(mask_o)
                                          && !init_stb_o && !ocw2_stb_o));

    assert_uninit_state_R13: assert property (@(posedge clk)
        $past(rst) |-> (init_state == INIT_NONE && bus_rdata == '0 && mask_o == '0));

endmodule

// File: tb/tb_pic_cmd_frontend.sv
module tb_pic_cmd_frontend;

    localparam time PERIOD = 10ns;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] core_irr = '0, core_isr = '0;
    logic       core_pend = 1'b0;
    logic [2:0] core_pend_lvl = '0;
    logic [7:0] mask_o, trig_mode_o;
    logic [4:0] vec_base_o;
    logic       nested_o, auto_eoi_o, rot_aeoi_o, spec_mask_o;
    logic       init_stb_o, ocw2_stb_o, poll_ack_o;
    logic [2:0] ocw2_op_o, ocw2_lvl_o;

    int total = 0, fails = 0;
    bit done = 1'b0;

    always #(PERIOD/2) clk = ~clk;

    pic_cmd_frontend dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .core_irr(core_irr),
        .core_isr(core_isr), .core_pend(core_pend), .core_pend_lvl(core_pend_lvl),
        .mask_o(mask_o), .vec_base_o(vec_base_o), .trig_mode_o(trig_mode_o),
        .nested_o(nested_o), .auto_eoi_o(auto_eoi_o), .rot_aeoi_o(rot_aeoi_o),
        .spec_mask_o(spec_mask_o), .init_stb_o(init_stb_o), .ocw2_stb_o(ocw2_stb_o),
        .ocw2_op_o(ocw2_op_o), .ocw2_lvl_o(ocw2_lvl_o), .poll_ack_o(poll_ack_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] r);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        r = bus_rdata;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        total++; fails++;
        $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
        finish_run();
    end

    initial begin
        logic [7:0] r;
        logic sm, rsel, rot, parm, nst, aeo;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R13: reset state
        chk("R13 mask", mask_o, 0);
        chk("R13 base", vec_base_o, 0);
        chk("R13 flags", {nested_o, auto_eoi_o, rot_aeoi_o, spec_mask_o, init_stb_o,
                          ocw2_stb_o, poll_ack_o}, 0);
        chk("R13 trig", trig_mode_o, 0);
        rd(2'd0, r); chk("R13 read", r, 0);
        // R6: uninitialized data write loads the mask
        wr(2'd1, 8'h5F); chk("R6 uninit mask", mask_o, 8'h5F);
        rd(2'd1, r); chk("R6 mask read", r, 8'h5F);
        @(negedge clk); chk("R11 idle rdata", bus_rdata, 0);

        // R1 R7 R8 R9 R12: sweep of every command byte
        core_irr = 8'hA5; core_isr = 8'h3C; core_pend = 1'b0;
        sm = 0; rsel = 0; rot = 0; parm = 0;
        for (int b = 0; b < 256; b++) begin
            logic [7:0] v;
            v = 8'(b);
            if (v[4]) begin
                sm = 0; rsel = 0;
            end else if (v[3]) begin
                if (v[2]) parm = 1;
                if (v[1]) rsel = v[0];
                if (v[6]) sm = v[5];
            end else begin
                if (v[7:5] == 3'b100) rot = 1;
                if (v[7:5] == 3'b000) rot = 0;
            end
            wr(2'd0, v);
            chk("R1 init strobe", init_stb_o, v[4]);
            chk("R1 ocw2 strobe", ocw2_stb_o, !v[4] && !v[3]);
            if (!v[4] && !v[3]) chk("R1 ocw2 fields", {ocw2_op_o, ocw2_lvl_o}, {v[7:5], v[2:0]});
            chk("R8 special mask", spec_mask_o, sm);
            chk("R12 rotate flag", rot_aeoi_o, rot);
            if (v[4]) chk("R2 mask cleared", mask_o, 0);
            rd(2'd0, r);
            if (parm) begin
                chk("R9 poll none", r, 8'h07);
                chk("R9 poll ack", poll_ack_o, 1);
                parm = 0;
            end else begin
                chk("R7 read select", r, rsel ? 8'h3C : 8'hA5);
                chk("R9 no ack", poll_ack_o, 0);
            end
        end

        // R2 R3 R4 R5 R6: initialization sequences, with and without word 4
        nst = 0; aeo = 0;
        for (int i = 0; i < 64; i++) begin
            logic [7:0] w2, w4b, m;
            logic four;
            four = i[0];
            w2 = 8'(i * 37 + 5);
            w4b = 8'(i * 53 + 3);
            m = 8'(i * 29 + 1);
            wr(2'd1, 8'hFF);
            wr(2'd0, {7'b0001000, four});
            chk("R2 init strobe", init_stb_o, 1);
            chk("R2 mask clear", mask_o, 0);
            if (!four) begin nst = 0; aeo = 0; end
            chk("R2 modes", {nested_o, auto_eoi_o}, {nst, aeo});
            wr(2'd1, w2);
            chk("R3 vector base", vec_base_o, w2[7:3]);
            wr(2'd1, 8'hEE);
            chk("R4 word3 discarded mask", mask_o, 0);
            chk("R4 word3 discarded base", vec_base_o, w2[7:3]);
            if (four) begin
                wr(2'd1, w4b);
                nst = w4b[4]; aeo = w4b[1];
                chk("R5 mode word", {nested_o, auto_eoi_o}, {nst, aeo});
            end
            wr(2'd1, m);
            chk("R6 idle mask", mask_o, m);
            chk("R4 modes kept", {nested_o, auto_eoi_o}, {nst, aeo});
        end

        // R9: poll with pending levels, on both ports
        for (int k = 0; k < 16; k++) begin
            core_pend = k[3]; core_pend_lvl = 3'(k);
            wr(2'd0, 8'h0C);
            rd(k[0] ? 2'd1 : 2'd0, r);
            chk("R9 poll byte", r, k[3] ? {5'b10000, 3'(k)} : 8'h07);
            chk("R9 poll ack", poll_ack_o, 1);
            rd(2'd1, r);
            chk("R9 disarmed", r, mask_o);
            chk("R9 ack once", poll_ack_o, 0);
        end

        // R10: trigger-mode register
        for (int t = 0; t < 256; t += 17) begin
            wr(2'd2, 8'(t));
            chk("R10 trig out", trig_mode_o, t);
            rd(2'd2, r);
            chk("R10 trig read", r, t);
        end

        // R11: unused address
        begin
            logic [7:0] tm, mk;
            tm = trig_mode_o; mk = mask_o;
            wr(2'd3, 8'h1C);
            chk("R11 trig kept", trig_mode_o, tm);
            chk("R11 mask kept", mask_o, mk);
            chk("R11 no strobe", {init_stb_o, ocw2_stb_o}, 0);
            rd(2'd3, r);
            chk("R11 read zero", r, 0);
        end

        finish_run();
    end

endmodule